// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it holds every strobe inactive for the supply-settling pause. It then runs a fixed number of warm-up cycles that each carry a RAS pulse, and raises a ready flag. From that point a periodic timer requests CAS-before-RAS refresh cycles. The average rate is set so that the whole row space is refreshed inside the retention window. The row count, the window length and the clock frequency in MHz are parameters, and every interval is derived from them as a cycle count.

The sequencer shares the DRAM strobes with an access controller through a request/grant handshake. While the controller holds the grant, due refreshes are not lost. They are counted in a saturating backlog and issued back to back once the controller lets go. A pending backlog is always drained before the bus is granted again. Warm-up cycles are also CAS-before-RAS cycles, so the block needs no address path at all.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low, ras_n_o, cas_lo_n_o and cas_hi_n_o are 1, and ready_o and bus_gnt_o are 0.
- R2: No falling edge of ras_n_o occurs earlier than PAUSE_CYC = PWRUP_US*CLK_MHZ clock cycles after reset is released.
- R3: After the pause, exactly INIT_CYCLES RAS pulses are issued and then ready_o rises to 1 with ras_n_o high. No grant is given while ready_o is 0.
- R4: In every cycle the block issues, both CAS strobes go low together T_CSR cycles before RAS falls, and both return high in the same cycle as RAS. we_n_o is always 1.
- R5: RAS stays low for exactly T_RAS cycles. Between two pulses RAS stays high for at least max(T_RP,T_CP)+T_CSR cycles.
- R6: When nothing is deferred, refresh RAS pulses are spaced by exactly INTERVAL = floor(REFRESH_MS*1000*CLK_MHZ/REFRESH_ROWS) cycles.
- R7: Refresh ticks that arrive while the bus is granted are counted up to PEND_MAX. After release, exactly min(ticks, PEND_MAX) refresh cycles are issued back to back, before the next regular tick.
- R8: bus_gnt_o is never 1 while ready_o is 0.
- R9: With ready_o at 1, no backlog and no cycle in progress, bus_req_i at 1 raises bus_gnt_o one cycle later. Dropping bus_req_i lowers bus_gnt_o one cycle later. While bus_gnt_o is 1, all strobes stay high.
- R10: A request raised while a backlog is pending is granted only after the whole backlog has been issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, CLK_MHZ MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access controller asks for the DRAM strobes |
| bus_gnt_o | output | 1 | Strobes handed to the access controller |
| ready_o | output | 1 | Power-up and warm-up finished |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_lo_n_o | output | 1 | Low-byte column strobe, active low |
| cas_hi_n_o | output | 1 | High-byte column strobe, active low |
| we_n_o | output | 1 | Write enable, held inactive (1) |

## Verification
The bench builds the block with CLK_MHZ=8. This gives a 1600-cycle power-up pause and a 125-cycle refresh interval, so start-up and many refresh periods fit into a short run. T_RAS=3, T_RP=2, T_CP=1 and T_CSR=1 make one refresh cycle seven clocks long. A full backlog of eight catch-up cycles then ends well before the next regular tick, so every catch-up count is exact. Holding the grant across ten ticks pushes the backlog into saturation at PEND_MAX=8 within roughly 1250 cycles.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_PRE,
    ENG_CSR,
    ENG_RAS
  } eng_state_e;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_cbr_engine.sv
module dram_cbr_engine
  import dram_seq_pkg::*;
#(
  parameter int unsigned T_PRE = 4,
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_RAS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic idle_o,
  output logic ras_n_o,
  output logic cas_n_o
);

  localparam int unsigned T_MAX = max_u(max_u(T_PRE, T_CSR), T_RAS);
  localparam int unsigned CW    = $clog2(T_MAX + 1);

  eng_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          ras_n_q, cas_n_q;

  // precharge first, then CAS ahead of RAS
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
    end else begin
      case (state_q)
        ENG_IDLE: if (start_i) begin
          state_q <= ENG_PRE;
          cnt_q   <= CW'(T_PRE - 1);
        end
        ENG_PRE: if (cnt_q == '0) begin
          state_q <= ENG_CSR;
          cas_n_q <= 1'b0;
          cnt_q   <= CW'(T_CSR - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ENG_CSR: if (cnt_q == '0) begin
          state_q <= ENG_RAS;
          ras_n_q <= 1'b0;
          cnt_q   <= CW'(T_RAS - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ENG_RAS: if (cnt_q == '0) begin
          state_q <= ENG_IDLE;
          ras_n_q <= 1'b1;
          cas_n_q <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign idle_o  = (state_q == ENG_IDLE);
  assign ras_n_o = ras_n_q;
  assign cas_n_o = cas_n_q;

  // checker-side run counters
  logic [15:0] low_run_q, high_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q  <= '0;
      high_run_q <= '0;
    end else begin
      low_run_q  <= ras_n_q ? '0 : low_run_q + 1'b1;
      high_run_q <= !ras_n_q ? '0 :
                    (high_run_q == 16'hFFFF) ? high_run_q : high_run_q + 1'b1;
    end
  end

  assert_cbr_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_q) |-> (!cas_n_q && $past(!cas_n_q)));

  assert_cas_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_q) |-> $rose(ras_n_q));

  assert_ras_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_q) |-> (low_run_q == 16'(T_RAS)));

  assert_ras_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_q) |-> (high_run_q >= 16'(T_PRE + T_CSR)));

endmodule

// File: rtl/dram_interval_timer.sv
module dram_interval_timer #(
  parameter int unsigned PERIOD = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  localparam int unsigned TW = $clog2(PERIOD + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= TW'(PERIOD - 1);
    else if (!en_i)             cnt_q <= TW'(PERIOD - 1);
    else if (cnt_q == '0)       cnt_q <= TW'(PERIOD - 1);
    else                        cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = en_i && (cnt_q == '0);

  // checker: spacing between ticks
  logic [TW-1:0] gap_q;
  logic          seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!en_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {TW{1'b1}}) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_tick_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && seen_q) |-> (gap_q == TW'(PERIOD - 1)));

endmodule

// File: rtl/dram_pend_counter.sv
module dram_pend_counter #(
  parameter int unsigned MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o
);

  localparam int unsigned PW = $clog2(MAX + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10:   if (cnt_q != PW'(MAX)) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign nz_o = (cnt_q != '0);

  assert_pend_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= MAX);

  assert_pend_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (($past(inc_i) != $past(dec_i))
      && ((32'(cnt_q) == 32'($past(cnt_q)) + 1) || (32'(cnt_q) + 1 == 32'($past(cnt_q))))));

  assert_no_drain_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> nz_o);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned PWRUP_US     = 200,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned REFRESH_ROWS = 4096,
  parameter int unsigned REFRESH_MS   = 64,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned T_RP         = 4,
  parameter int unsigned T_CP         = 2,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned PEND_MAX     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_req_i,
  output logic bus_gnt_o,
  output logic ready_o,
  output logic ras_n_o,
  output logic cas_lo_n_o,
  output logic cas_hi_n_o,
  output logic we_n_o
);

  localparam int unsigned PAUSE_CYC = PWRUP_US * CLK_MHZ;
  localparam int unsigned INTERVAL  = (REFRESH_MS * 1000 * CLK_MHZ) / REFRESH_ROWS;
  localparam int unsigned T_PRE     = max_u(T_RP, T_CP);
  localparam int unsigned PCW       = $clog2(PAUSE_CYC + 1);
  localparam int unsigned ICW       = $clog2(INIT_CYCLES + 1);

  phase_e         phase_q;
  logic [PCW-1:0] pause_cnt_q;
  logic [ICW-1:0] init_cnt_q;
  logic           gnt_q;

  logic eng_idle, eng_ras_n, eng_cas_n;
  logic tick, pend_nz, start, run;

  assign run = (phase_q == PH_RUN);

  // backlog drains before any grant
  always_comb begin
    start = 1'b0;
    if (eng_idle && !gnt_q) begin
      if (phase_q == PH_INIT) start = (init_cnt_q < ICW'(INIT_CYCLES));
      else if (run)           start = pend_nz;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_PAUSE;
      pause_cnt_q <= '0;
      init_cnt_q  <= '0;
      gnt_q       <= 1'b0;
    end else begin
      case (phase_q)
        PH_PAUSE:
          if (pause_cnt_q == PCW'(PAUSE_CYC - 1)) phase_q <= PH_INIT;
          else pause_cnt_q <= pause_cnt_q + 1'b1;
        PH_INIT: begin
          if (start) init_cnt_q <= init_cnt_q + 1'b1;
          if (eng_idle && init_cnt_q == ICW'(INIT_CYCLES)) phase_q <= PH_RUN;
        end
        PH_RUN:
          if (gnt_q) begin
            if (!bus_req_i) gnt_q <= 1'b0;
          end else if (eng_idle && !pend_nz && bus_req_i) begin
            gnt_q <= 1'b1;
          end
        default: phase_q <= PH_PAUSE;
      endcase
    end
  end

  dram_interval_timer #(.PERIOD(INTERVAL)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .tick_o (tick)
  );

  dram_pend_counter #(.MAX(PEND_MAX)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (start && run),
    .nz_o   (pend_nz)
  );

  dram_cbr_engine #(.T_PRE(T_PRE), .T_CSR(T_CSR), .T_RAS(T_RAS)) i_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .idle_o  (eng_idle),
    .ras_n_o (eng_ras_n),
    .cas_n_o (eng_cas_n)
  );

  assign bus_gnt_o  = gnt_q;
  assign ready_o    = run;
  assign ras_n_o    = eng_ras_n;
  assign cas_lo_n_o = eng_cas_n;
  assign cas_hi_n_o = eng_cas_n;
  assign we_n_o     = 1'b1;

  assert_pause_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PAUSE) |-> (ras_n_o && cas_lo_n_o && cas_hi_n_o));

  assert_ready_after_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (ras_n_o && $past(init_cnt_q) == ICW'(INIT_CYCLES)));

  assert_no_early_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_o |-> ready_o);

  assert_strobes_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_o |-> (ras_n_o && cas_lo_n_o && cas_hi_n_o && eng_idle));

  assert_grant_blocked_by_backlog_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_gnt_o) |-> $past(!pend_nz));

endmodule

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;

  localparam int CLK_MHZ   = 8;
  localparam int PWRUP_US  = 200;
  localparam int INIT_N    = 8;
  localparam int ROWS      = 4096;
  localparam int WIN_MS    = 64;
  localparam int T_RAS     = 3;
  localparam int T_RP      = 2;
  localparam int T_CP      = 1;
  localparam int T_CSR     = 1;
  localparam int PEND_MAX  = 8;
  localparam int PAUSE_CYC = PWRUP_US * CLK_MHZ;
  localparam int INTERVAL  = (WIN_MS * 1000 * CLK_MHZ) / ROWS;
  localparam int T_PRE     = (T_RP > T_CP) ? T_RP : T_CP;
  localparam int LAT       = 2 + T_PRE + T_CSR; // tick cycle to RAS fall

  localparam int VEC_N = 5;
  localparam int HOLD_TICKS [VEC_N] = '{0, 1, 3, 8, 10};
  localparam int EXP_CATCH  [VEC_N] = '{0, 1, 3, 8, 8};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_req_i = 1'b0;
  logic bus_gnt_o, ready_o, ras_n_o, cas_lo_n_o, cas_hi_n_o, we_n_o;

  always #2 clk_i = ~clk_i;

  dram_refresh_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .INIT_CYCLES(INIT_N),
    .REFRESH_ROWS(ROWS), .REFRESH_MS(WIN_MS), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_CP(T_CP), .T_CSR(T_CSR), .PEND_MAX(PEND_MAX)
  ) i_dram_refresh_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_gnt_o(bus_gnt_o),
    .ready_o(ready_o), .ras_n_o(ras_n_o), .cas_lo_n_o(cas_lo_n_o),
    .cas_hi_n_o(cas_hi_n_o), .we_n_o(we_n_o)
  );

  int cyc = 0;
  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe monitor
  int  fall_cnt = 0, last_fall = 0, first_fall = -1;
  int  low_run = 0, high_run = 0, cas_run = 0;
  int  we_bad = 0, early_gnt = 0, gnt_strobe_bad = 0, cas_split = 0;
  bit  prev_ras = 1'b1;

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (prev_ras && !ras_n_o) begin
        fall_cnt++;
        last_fall = cyc;
        if (first_fall < 0) first_fall = cyc;
        check(cas_run == T_CSR, "R4 cas lead before ras fall", cas_run, T_CSR);
        if (fall_cnt > 1)
          check(high_run >= T_PRE + T_CSR, "R5 ras precharge", high_run, T_PRE + T_CSR);
      end
      if (!prev_ras && ras_n_o) begin
        check(low_run == T_RAS, "R5 ras low width", low_run, T_RAS);
        check(cas_lo_n_o && cas_hi_n_o, "R4 cas release with ras",
              int'({cas_hi_n_o, cas_lo_n_o}), 3);
      end
      low_run  = !ras_n_o ? low_run + 1 : 0;
      high_run = ras_n_o ? high_run + 1 : 0;
      cas_run  = (!cas_lo_n_o && !cas_hi_n_o && ras_n_o) ? cas_run + 1 : 0;
      if (cas_lo_n_o != cas_hi_n_o) cas_split++;
      if (!we_n_o) we_bad++;
      if (bus_gnt_o && !ready_o) early_gnt++;
      if (bus_gnt_o && !(ras_n_o && cas_lo_n_o && cas_hi_n_o)) gnt_strobe_bad++;
      prev_ras = ras_n_o;
    end
  end

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk_i);
  endtask

  task automatic wait_fall(output int f);
    int base;
    base = fall_cnt;
    while (fall_cnt == base) @(negedge clk_i);
    f = last_fall;
  endtask

  initial begin
    int exp_next;
    int f0, c0, drop, base, got;
    exp_next = -1;

    // R1: reset state, request already pending
    bus_req_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(ras_n_o && cas_lo_n_o && cas_hi_n_o, "R1 strobes high in reset",
          int'({ras_n_o, cas_hi_n_o, cas_lo_n_o}), 7);
    check(!ready_o && !bus_gnt_o, "R1 ready/grant low in reset",
          int'({ready_o, bus_gnt_o}), 0);
    rst_ni = 1'b1;

    while (!ready_o) @(negedge clk_i);
    check(first_fall >= PAUSE_CYC, "R2 pause before first ras", first_fall, PAUSE_CYC);
    check(fall_cnt == INIT_N, "R3 warm-up pulse count", fall_cnt, INIT_N);
    check(ras_n_o == 1'b1, "R3 ras high at ready", int'(ras_n_o), 1);
    @(negedge clk_i);
    check(bus_gnt_o == 1'b1, "R9 grant one cycle after ready", int'(bus_gnt_o), 1);
    bus_req_i = 1'b0;
    @(negedge clk_i);
    check(bus_gnt_o == 1'b0, "R9 grant drops after request", int'(bus_gnt_o), 0);

    // vector table: grant held over K ticks, expected catch-up count
    for (int v = 0; v < VEC_N; v++) begin
      wait_fall(f0);
      if (exp_next >= 0) check(f0 == exp_next, "R6 refresh spacing", f0, exp_next);
      c0 = f0 - LAT;
      wait_cyc(c0 + INTERVAL - 20);
      bus_req_i = 1'b1;
      @(negedge clk_i);
      check(bus_gnt_o == 1'b1, "R9 grant when idle", int'(bus_gnt_o), 1);
      drop = (HOLD_TICKS[v] == 0) ? c0 + INTERVAL - 10 : c0 + HOLD_TICKS[v] * INTERVAL + 5;
      wait_cyc(drop);
      bus_req_i = 1'b0;
      base = fall_cnt;
      @(negedge clk_i);
      check(bus_gnt_o == 1'b0, "R9 release", int'(bus_gnt_o), 0);
      wait_cyc(c0 + (HOLD_TICKS[v] + 1) * INTERVAL + LAT - 1);
      got = fall_cnt - base;
      check(got == EXP_CATCH[v], "R7 catch-up count", got, EXP_CATCH[v]);
      exp_next = c0 + (HOLD_TICKS[v] + 1) * INTERVAL + LAT;
    end

    // R10: request re-raised while a backlog of two is pending
    wait_fall(f0);
    check(f0 == exp_next, "R6 refresh spacing after saturation", f0, exp_next);
    c0 = f0 - LAT;
    wait_cyc(c0 + INTERVAL - 20);
    bus_req_i = 1'b1;
    wait_cyc(c0 + 2 * INTERVAL + 5);
    bus_req_i = 1'b0;
    base = fall_cnt;
    @(negedge clk_i);
    bus_req_i = 1'b1;
    while (!bus_gnt_o) @(negedge clk_i);
    check(fall_cnt - base == 2, "R10 backlog before regrant", fall_cnt - base, 2);
    check(ras_n_o == 1'b1, "R10 ras idle at regrant", int'(ras_n_o), 1);
    bus_req_i = 1'b0;
    repeat (4) @(negedge clk_i);

    check(we_bad == 0, "R4 write enable held high", we_bad, 0);
    check(cas_split == 0, "R4 both cas strobes together", cas_split, 0);
    check(early_gnt == 0, "R8 no grant before ready", early_gnt, 0);
    check(gnt_strobe_bad == 0, "R9 strobes high while granted", gnt_strobe_bad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule